// File: doc/BRIEF.md
# Coherent Three-Channel Input Capture Unit

This peripheral watches three capture pins and stamps events with time from a 16-bit free-running counter. The counter advances once per bus cycle, marked by a bus-cycle enable. Each pin passes through a two-flop synchronizer and then an edge detector whose sensitivity is set by two control bits per channel. When a selected edge is detected, the whole counter value moves into that channel's capture register in a single parallel load. The register is one of three, one per channel.

Software reads each capture value as two read-only bytes over an 8-bit read port. A read of the high byte keeps the channel's register frozen through the end of that bus cycle, so a low-byte read in the next cycle returns the other half of the same value.

An edge detected during that frozen cycle is not lost. Each channel runs a two-state machine:
- **CH_IDLE**: no capture is waiting.
  - Transition *load*: an edge with no high-byte read loads the counter directly and stays in CH_IDLE.
  - Transition *defer*: an edge together with a high-byte read latches the counter into a pending holder and moves to CH_PEND.
- **CH_PEND**: a capture is waiting in the pending holder.
  - Transition *still-blocked*: another high-byte read keeps the state in CH_PEND.
  - Transition *commit*: a cycle without a high-byte read writes the pending value, or a fresher edge's counter value, into the register and returns to CH_IDLE.

Reset clears the counter, the synchronizers and the state machines. It leaves the capture registers alone.

Top module: `tic_capture_unit`

## Requirements
- R1: The counter is 0 after reset. It adds 1 at every clock edge where `bus_en` is 1, holds when `bus_en` is 0, and wraps from 0xFFFF to 0x0000.
- R2: Suppose a new pin level is first sampled at enabled edge k. The edge is then detected at enabled edge k+2, and at that edge the capture register loads the counter value held just before edge k+2.
- R3: Edge selection uses bits [2c+1:2c] of `edge_sel` for channel c. Code 00 disables the channel, 01 selects rising edges, 10 selects falling edges and 11 selects both. An edge that is not selected leaves the register unchanged.
- R4: While `rd_stb` is 1, `rd_data` shows the high byte (bits 15:8) of channel c at address 0x10+2c and the low byte (bits 7:0) at 0x11+2c, for c = 0..2. Any other address, or `rd_stb` at 0, gives 0x00.
- R5: In a bus cycle with a high-byte read of channel c, channel c's register does not change at the end of that cycle. A low-byte read in the next cycle therefore matches the high byte just read.
- R6: An edge detected in a high-byte-read cycle is committed at the end of the next bus cycle that has no high-byte read of that channel. The committed value is the counter value from the detection cycle.
- R7: Back-to-back high-byte reads keep a deferred capture waiting, and the captured value is kept unchanged while it waits.
- R8: A high-byte read of one channel does not delay a capture on another channel.
- R9: Asserting reset does not change any capture register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of counter, synchronizers and state machines |
| bus_en | input | 1 | Marks a bus cycle; all state advances only when high |
| cap_pin | input | 3 | Asynchronous capture pins, bit c for channel c |
| edge_sel | input | 6 | Edge sensitivity, two bits per channel |
| rd_addr | input | 8 | Byte address of the read |
| rd_stb | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, combinational from address |

## Verification
Single edges on each channel are tried in every sensitivity mode. This separates rising, falling, both and disabled decoding, and checks that the stamped value carries exactly the two-cycle synchronizer latency.

Edges timed to land in a high-byte read cycle are followed by a low-byte read, by a second high-byte read, or by a read of another channel. This tells a correctly deferred capture apart from one that is dropped, one that lands early and tears the byte pair, or one that stamps the later counter value.

Captures after an idle gap in `bus_en` and at the 0xFFFF boundary separate counting on bus cycles from counting on clocks and confirm the wrap. A reset between captures shows the registers survive it.

// File: rtl/tic_pkg.sv
package tic_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_PEND = 1'b1
    } chan_state_e;
endpackage

// File: rtl/tic_free_counter.sv
module tic_free_counter
    import tic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [CNT_W-1:0] count
);
    // Advances at the clock edge that closes each bus cycle; the capture
    // path samples the registered value, which is stable all cycle long.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (en) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/tic_edge_sync.sv
module tic_edge_sync (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       pin,
    input  logic [1:0] sel,
    output logic       hit
);
    logic meta_q;
    logic sync_q;
    logic last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else if (en) begin
            meta_q <= pin;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    logic rise;
    logic fall;
    assign rise = sync_q & ~last_q;
    assign fall = ~sync_q & last_q;
    assign hit  = en & ((sel[0] & rise) | (sel[1] & fall));
endmodule

// File: rtl/tic_capture_chan.sv
module tic_capture_chan
    import tic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hit,
    input  logic             hi_rd,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap,
    output logic             pend
);
    chan_state_e st_q;
    chan_state_e st_d;
    logic        load_now;
    logic        load_held;
    logic        take_held;
    logic [CNT_W-1:0] held_q;

    always_comb begin
        st_d      = st_q;
        load_now  = 1'b0;
        load_held = 1'b0;
        take_held = 1'b0;
        if (en) begin
            unique case (st_q)
                CH_IDLE: begin
                    if (hit && hi_rd) begin
                        take_held = 1'b1;
                        st_d      = CH_PEND;
                    end else if (hit) begin
                        load_now  = 1'b1;
                    end
                end
                CH_PEND: begin
                    if (hi_rd) begin
                        take_held = hit;
                    end else begin
                        st_d      = CH_IDLE;
                        load_now  = hit;
                        load_held = ~hit;
                    end
                end
            endcase
        end
    end

    // State register: the only reset flops of the channel.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Output data path: capture and pending holder keep their value over reset.
    always_ff @(posedge clk) begin
        if (take_held) begin
            held_q <= count;
        end
        if (load_now) begin
            cap <= count;
        end else if (load_held) begin
            cap <= held_q;
        end
    end

    assign pend = (st_q == CH_PEND);
endmodule

// File: rtl/tic_capture_unit.sv
module tic_capture_unit
    import tic_pkg::*;
#(
    parameter int          NUM_CH    = 3,
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  BASE_ADDR = 8'h10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_en,
    input  logic [NUM_CH-1:0]     cap_pin,
    input  logic [2*NUM_CH-1:0]   edge_sel,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic                  rd_stb,
    output logic [BYTE_W-1:0]     rd_data
);
    localparam int BYTES_PER_CH = CNT_W / BYTE_W;

    logic [CNT_W-1:0]             cnt_q;
    logic [NUM_CH-1:0][CNT_W-1:0] cap_q;
    logic [NUM_CH-1:0]            pend_q;
    logic [NUM_CH-1:0]            hit;
    logic [NUM_CH-1:0]            hi_rd;

    tic_free_counter u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (bus_en),
        .count (cnt_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(BASE_ADDR + BYTES_PER_CH * c);

        assign hi_rd[c] = bus_en & rd_stb & (rd_addr == HI_ADDR);

        tic_edge_sync u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (bus_en),
            .pin   (cap_pin[c]),
            .sel   (edge_sel[2*c +: 2]),
            .hit   (hit[c])
        );

        tic_capture_chan u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (bus_en),
            .hit   (hit[c]),
            .hi_rd (hi_rd[c]),
            .count (cnt_q),
            .cap   (cap_q[c]),
            .pend  (pend_q[c])
        );
    end

    always_comb begin
        rd_data = '0;
        if (rd_stb) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (rd_addr == ADDR_W'(BASE_ADDR + BYTES_PER_CH * c)) begin
                    rd_data = cap_q[c][CNT_W-1 -: BYTE_W];
                end else if (rd_addr == ADDR_W'(BASE_ADDR + BYTES_PER_CH * c + 1)) begin
                    rd_data = cap_q[c][BYTE_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/tic_capture_unit_chk.sv
module tic_capture_unit_chk
    import tic_pkg::*;
#(
    parameter int          NUM_CH    = 3,
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  BASE_ADDR = 8'h10
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_en,
    input logic                         rd_stb,
    input logic [ADDR_W-1:0]            rd_addr,
    input logic [BYTE_W-1:0]            rd_data,
    input logic [CNT_W-1:0]             cnt_q,
    input logic [NUM_CH-1:0][CNT_W-1:0] cap_q,
    input logic [NUM_CH-1:0]            pend_q
);
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    a_r1_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> $stable(cnt_q));

    a_r4_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |-> (rd_data == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BASE_ADDR + 2 * c);

        a_r5_hi_read_freeze: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_en && rd_stb && rd_addr == HI_A) |=> $stable(cap_q[c]));

        a_r6_pend_resolves: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[c] && bus_en && !(rd_stb && rd_addr == HI_A)) |=> !pend_q[c]);

        a_r7_pend_waits: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[c] && (!bus_en || (rd_stb && rd_addr == HI_A))) |=> pend_q[c]);
    end
endmodule

bind tic_capture_unit tic_capture_unit_chk #(
    .NUM_CH    (NUM_CH),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_en  (bus_en),
    .rd_stb  (rd_stb),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .cnt_q   (cnt_q),
    .cap_q   (cap_q),
    .pend_q  (pend_q)
);

// File: tb/tic_capture_unit_tb_top.sv
module tic_capture_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b1;
    logic [2:0] cap_pin = '0;
    logic [5:0] edge_sel = '0;
    logic [7:0] rd_addr = '0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;

    int n_vec = 0;
    int n_bad = 0;

    typedef struct {
        int          ch;
        logic [15:0] val;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    logic [15:0] last_exp [3];
    logic [15:0] model_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    tic_capture_unit dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_en   (bus_en),
        .cap_pin  (cap_pin),
        .edge_sel (edge_sel),
        .rd_addr  (rd_addr),
        .rd_stb   (rd_stb),
        .rd_data  (rd_data)
    );

    // Independent counter model built from R1.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n)      model_cnt <= '0;
        else if (bus_en) model_cnt <= model_cnt + 16'd1;
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk16(string req, logic [15:0] act, logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge; strobe is held across the next posedge.
    task automatic rd_byte(logic [7:0] a, output logic [7:0] d);
        rd_addr = a;
        rd_stb  = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_stb  = 1'b0;
    endtask

    task automatic rd_pair(int ch, output logic [15:0] v);
        logic [7:0] h, l;
        rd_byte(8'(8'h10 + 2*ch), h);
        rd_byte(8'(8'h11 + 2*ch), l);
        v = {h, l};
    endtask

    // Driver: changes a pin and pushes the expected register content.
    task automatic drive_pin(int ch, logic lvl, bit captures, string req);
        exp_t e;
        logic [15:0] v;
        v = model_cnt;
        cap_pin[ch] = lvl;
        e.ch  = ch;
        e.val = captures ? 16'(v + 16'd2) : last_exp[ch];
        e.req = req;
        last_exp[ch] = e.val;
        sb_q.push_back(e);
        tick(3);
    endtask

    // Monitor: pops the oldest expectation and compares a coherent read.
    task automatic monitor_next();
        exp_t e;
        logic [15:0] got;
        e = sb_q.pop_front();
        rd_pair(e.ch, got);
        chk16(e.req, got, e.val);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0]  b0, b1, b2;
        logic [15:0] v;
        logic [15:0] old0;
        exp_t        e;

        edge_sel = {2'b11, 2'b01, 2'b01};
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R4: idle bus and unmapped addresses read zero
        #1 chk8("R4 idle strobe", rd_data, 8'h00);
        rd_byte(8'h16, b0); chk8("R4 unmapped 0x16", b0, 8'h00);
        rd_byte(8'h0F, b0); chk8("R4 unmapped 0x0F", b0, 8'h00);

        // R2: rising edge on channel 0 stamps counter with sync latency
        drive_pin(0, 1'b1, 1'b1, "R2 ch0 rising latency"); monitor_next();
        // R3: rising on ch1
        drive_pin(1, 1'b1, 1'b1, "R3 ch1 rising");         monitor_next();
        edge_sel[3:2] = 2'b10;
        drive_pin(1, 1'b0, 1'b1, "R3 ch1 falling");        monitor_next();
        drive_pin(1, 1'b1, 1'b0, "R3 ch1 rise ignored in falling mode"); monitor_next();
        drive_pin(2, 1'b1, 1'b1, "R3 ch2 both, rise");     monitor_next();
        drive_pin(2, 1'b0, 1'b1, "R3 ch2 both, fall");     monitor_next();
        edge_sel[1:0] = 2'b00;
        drive_pin(0, 1'b0, 1'b0, "R3 ch0 disabled fall");  monitor_next();
        drive_pin(0, 1'b1, 1'b0, "R3 ch0 disabled rise");  monitor_next();
        edge_sel[1:0] = 2'b11;
        tick(3);

        // R5/R6: edge detected in the high-read cycle is deferred one cycle
        old0 = last_exp[0];
        v = model_cnt;
        cap_pin[0] = 1'b0;
        tick(2);
        rd_byte(8'h10, b0);
        rd_byte(8'h11, b1);
        chk16("R5 coherent pair during hold-off", {b0, b1}, old0);
        e.ch = 0; e.val = 16'(v + 16'd2); e.req = "R6 deferred value from detection cycle";
        last_exp[0] = e.val; sb_q.push_back(e);
        tick(1); monitor_next();

        // R7: two back-to-back high reads keep the capture waiting
        old0 = last_exp[0];
        v = model_cnt;
        cap_pin[0] = 1'b1;
        tick(2);
        rd_byte(8'h10, b0);
        rd_byte(8'h10, b1);
        rd_byte(8'h11, b2);
        chk16("R7 still old after repeated high read", {b1, b2}, old0);
        e.ch = 0; e.val = 16'(v + 16'd2); e.req = "R7 deferred value kept";
        last_exp[0] = e.val; sb_q.push_back(e);
        tick(1); monitor_next();

        // R8: ch0 high read does not delay a ch1 capture
        v = model_cnt;
        cap_pin[1] = 1'b0;
        tick(2);
        rd_byte(8'h10, b0);
        rd_byte(8'h13, b1);
        chk8("R8 ch1 low byte updated on time", b1, 8'(v + 16'd2));
        last_exp[1] = 16'(v + 16'd2);
        e.ch = 1; e.val = last_exp[1]; e.req = "R8 ch1 full value";
        sb_q.push_back(e);
        monitor_next();

        // R1: counter holds while bus_en is low
        bus_en = 1'b0;
        tick(7);
        bus_en = 1'b1;
        tick(1);
        drive_pin(2, 1'b1, 1'b1, "R1 hold during idle bus cycles"); monitor_next();

        // R1: wrap from 0xFFFF to 0x0000
        while (model_cnt != 16'hFFFE) @(negedge clk);
        drive_pin(2, 1'b0, 1'b1, "R1 wrap to zero"); monitor_next();
        chk16("R1 wrap expected literal", last_exp[2], 16'h0000);

        // R9: reset leaves capture registers untouched
        edge_sel = '0;
        cap_pin  = '0;
        tick(4);
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        for (int c = 0; c < 3; c++) begin
            rd_pair(c, v);
            chk16("R9 register survives reset", v, last_exp[c]);
        end

        finish_run();
    end
endmodule